// File: doc/BRIEF.md
# Illegal Opcode Trap and Next-PC Control

This block sits at the end of decode in a 32-bit processor whose instructions carry a 6-bit opcode. It checks each accepted instruction against a mask of the opcodes that the hardware implements. It then selects the next program counter. It also either passes the datapath's normal write-back and memory request through, or cancels them and enters a trap. An instruction whose opcode is not implemented never takes effect. Instead, the PC is redirected to a fixed supervisor vector, and the address of the following instruction is written into a reserved general register. Trap software can use that address to emulate the instruction and then resume.

Privilege lives in bit 31 of the PC. Both trap vectors have that bit set, so a handler always runs privileged. Normal sequencing and branches from user code can never set the bit. A user-mode external interrupt enters through the same redirect and link-write path as an illegal opcode, at a different vector.

Each accepted instruction (`valid_i` high and `stall_i` low) produces one registered result on the outputs at the next rising clock edge.

Top module: `illop_trap_unit`

## Requirements
- R1: The opcode is `instr_i[31:26]`. An opcode is legal exactly when bit `opcode` of parameter `IMPL_MASK` is 1. The default mask leaves opcodes 1, 2, 16 to 31 and 56 to 59 unimplemented.
- R2: One cycle after an accepted illegal instruction, `trap_o` is 1 and `next_pc_o` is 0x80000004.
- R3: A trapping instruction performs no memory access (`mem_en_o` is 0), and its own register write is replaced by the link write.
- R4: On any trap, `rf_we_o` is 1, `rf_waddr_o` is 30, and `rf_wdata_o` is the trapping PC plus 4. Bit 31 of that value is copied from the PC, and bits 30:0 wrap without carrying into bit 31.
- R5: An illegal instruction fetched with PC bit 31 set traps to the same vector, and the next PC keeps bit 31 set.
- R6: An accepted legal non-branch instruction that does not trap gives `next_pc_o` = {PC[31], PC[30:0]+4}. The increment never changes bit 31.
- R7: A legal instruction with `br_take_i` high, no trap, gives `next_pc_o` bits 30:0 = `br_target_i[30:0]`, and bit 31 = PC[31] AND `br_target_i[31]`.
- R8: `irq_i` high with a legal accepted instruction and PC bit 31 clear traps to 0x80000008, with the same link write as R4. With PC bit 31 set, `irq_i` is ignored.
- R9: When an illegal opcode and a takeable interrupt arrive together, the illegal-opcode vector 0x80000004 is used.
- R10: In a cycle after a non-accepted slot (`valid_i` low or `stall_i` high), `trap_o`, `rf_we_o` and `mem_en_o` are 0, and `next_pc_o` holds its value.
- R11: During and straight after reset, `next_pc_o` is 0x80000000, and `trap_o`, `rf_we_o` and `mem_en_o` are 0.
- R12: An accepted legal instruction without a trap passes `dp_we_i`, `dp_wdata_i` and `dp_mem_i` through. It writes to register index `instr_i[25:21]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction slot holds a real instruction |
| stall_i | input | 1 | Hold the slot; no result this cycle |
| pc_i | input | 32 | PC of the instruction, bit 31 = supervisor |
| instr_i | input | 32 | Instruction word |
| irq_i | input | 1 | External interrupt request |
| br_take_i | input | 1 | Instruction is a taken branch |
| br_target_i | input | 32 | Branch target address |
| dp_we_i | input | 1 | Datapath's normal register write enable |
| dp_wdata_i | input | 32 | Datapath's normal write data |
| dp_mem_i | input | 1 | Datapath's memory access request |
| next_pc_o | output | 32 | Registered next PC |
| trap_o | output | 1 | Pulses in the cycle a trap redirect is taken |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| mem_en_o | output | 1 | Memory access enable |

## Verification
Every result of an accepted slot appears exactly one rising edge after that slot: the next PC, the trap pulse, the link or pass-through write, and the memory enable. The bench changes the inputs on the falling edge. Before that edge it computes the expected outputs from the inputs it is about to apply. It compares them on the following falling edge, which is half a period after the registering edge. For a stalled or empty slot, the bench checks at that same point that the outputs went quiet and that the PC held.

// File: rtl/trapu_pkg.sv
package trapu_pkg;
  localparam int XLEN = 32;
  localparam int OPW  = 6;
  localparam int RAW  = 5;

  typedef enum logic [1:0] {RD_SEQ, RD_BR, RD_ILL, RD_IRQ} redir_e;

  function automatic logic [OPW-1:0] opcode_of(input logic [XLEN-1:0] ins);
    return ins[XLEN-1 -: OPW];
  endfunction

  function automatic logic [RAW-1:0] dest_of(input logic [XLEN-1:0] ins);
    return ins[XLEN-OPW-1 -: RAW];
  endfunction

  // Sequential successor: the low bits wrap, the privilege bit is kept.
  function automatic logic [XLEN-1:0] seq_pc(input logic [XLEN-1:0] pc);
    logic [XLEN-2:0] low;
    low = pc[XLEN-2:0] + (XLEN-1)'(4);
    return {pc[XLEN-1], low};
  endfunction

  // Branch target: privilege may be kept or dropped, never gained.
  function automatic logic [XLEN-1:0] branch_pc(input logic [XLEN-1:0] pc,
                                                input logic [XLEN-1:0] tgt);
    return {pc[XLEN-1] & tgt[XLEN-1], tgt[XLEN-2:0]};
  endfunction
endpackage

// File: rtl/trapu_opc_decode.sv
module trapu_opc_decode #(
  parameter int OPW = 6,
  parameter logic [(1<<OPW)-1:0] MASK = '1
) (
  input  logic [OPW-1:0] opc,
  output logic           legal
);
  localparam int NOPC = 1 << OPW;
  logic [NOPC-1:0] hit;

  for (genvar g = 0; g < NOPC; g++) begin : g_slot
    assign hit[g] = (opc == OPW'(g)) && MASK[g];
  end

  assign legal = |hit;
endmodule

// File: rtl/trapu_nextpc.sv
module trapu_nextpc
  import trapu_pkg::*;
#(
  parameter logic [XLEN-1:0] ILL_VEC = 32'h8000_0004,
  parameter logic [XLEN-1:0] IRQ_VEC = 32'h8000_0008
) (
  input  redir_e            kind,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   tgt,
  output logic [XLEN-1:0]   npc
);
  always_comb begin
    unique case (kind)
      RD_ILL:  npc = ILL_VEC;
      RD_IRQ:  npc = IRQ_VEC;
      RD_BR:   npc = branch_pc(pc, tgt);
      default: npc = seq_pc(pc);
    endcase
  end

  // R7: a user-mode branch never produces a privileged PC
  always_comb begin
    if (kind == RD_BR && !pc[XLEN-1])
      a_r7_branch_no_raise: assert (!npc[XLEN-1]);
  end
endmodule

// File: rtl/trapu_wb.sv
module trapu_wb
  import trapu_pkg::*;
#(
  parameter int LINK_IDX = 30
) (
  input  redir_e            kind,
  input  logic [XLEN-1:0]   pc,
  input  logic [RAW-1:0]    dest,
  input  logic              dp_we,
  input  logic [XLEN-1:0]   dp_wdata,
  input  logic              dp_mem,
  output logic              we,
  output logic [RAW-1:0]    waddr,
  output logic [XLEN-1:0]   wdata,
  output logic              mem
);
  logic trapping;
  assign trapping = (kind == RD_ILL) || (kind == RD_IRQ);

  always_comb begin
    if (trapping) begin
      we    = 1'b1;
      waddr = RAW'(LINK_IDX);
      wdata = seq_pc(pc);
      mem   = 1'b0;
    end else begin
      we    = dp_we;
      waddr = dest;
      wdata = dp_wdata;
      mem   = dp_mem;
    end
  end
endmodule

// File: rtl/illop_trap_unit.sv
module illop_trap_unit
  import trapu_pkg::*;
#(
  parameter logic [63:0]     IMPL_MASK = 64'hF0FF_FFFF_0000_FFF9,
  parameter logic [XLEN-1:0] ILL_VEC   = 32'h8000_0004,
  parameter logic [XLEN-1:0] IRQ_VEC   = 32'h8000_0008,
  parameter logic [XLEN-1:0] RESET_PC  = 32'h8000_0000,
  parameter int              LINK_IDX  = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic            stall_i,
  input  logic [31:0]     pc_i,
  input  logic [31:0]     instr_i,
  input  logic            irq_i,
  input  logic            br_take_i,
  input  logic [31:0]     br_target_i,
  input  logic            dp_we_i,
  input  logic [31:0]     dp_wdata_i,
  input  logic            dp_mem_i,
  output logic [31:0]     next_pc_o,
  output logic            trap_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [31:0]     rf_wdata_o,
  output logic            mem_en_o
);
  // Named internal events
  logic            accept;
  logic            legal;
  logic            irq_take;
  logic            trap_evt;
  redir_e          kind;
  logic [XLEN-1:0] npc_d;
  logic            we_d, mem_d;
  logic [RAW-1:0]  waddr_d;
  logic [XLEN-1:0] wdata_d;
  logic            acc_q;
  logic            unused_imm;

  assign unused_imm = ^instr_i[XLEN-OPW-RAW-1:0];
  assign accept     = valid_i && !stall_i;

  trapu_opc_decode #(.OPW(OPW), .MASK(IMPL_MASK)) u_dec (
    .opc   (opcode_of(instr_i)),
    .legal (legal)
  );

  assign irq_take = irq_i && !pc_i[XLEN-1] && legal;
  assign trap_evt = accept && (!legal || irq_take);

  always_comb begin
    if (!legal)          kind = RD_ILL;
    else if (irq_take)   kind = RD_IRQ;
    else if (br_take_i)  kind = RD_BR;
    else                 kind = RD_SEQ;
  end

  trapu_nextpc #(.ILL_VEC(ILL_VEC), .IRQ_VEC(IRQ_VEC)) u_npc (
    .kind (kind),
    .pc   (pc_i),
    .tgt  (br_target_i),
    .npc  (npc_d)
  );

  trapu_wb #(.LINK_IDX(LINK_IDX)) u_wb (
    .kind     (kind),
    .pc       (pc_i),
    .dest     (dest_of(instr_i)),
    .dp_we    (dp_we_i),
    .dp_wdata (dp_wdata_i),
    .dp_mem   (dp_mem_i),
    .we       (we_d),
    .waddr    (waddr_d),
    .wdata    (wdata_d),
    .mem      (mem_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc_o  <= RESET_PC;
      trap_o     <= 1'b0;
      rf_we_o    <= 1'b0;
      rf_waddr_o <= '0;
      rf_wdata_o <= '0;
      mem_en_o   <= 1'b0;
      acc_q      <= 1'b0;
    end else begin
      acc_q    <= accept;
      trap_o   <= trap_evt;
      rf_we_o  <= accept && we_d;
      mem_en_o <= accept && mem_d;
      if (accept) begin
        next_pc_o  <= npc_d;
        rf_waddr_o <= waddr_d;
        rf_wdata_o <= wdata_d;
      end
    end
  end

  // R2 / R5 / R8: every trap lands in a privileged vector
  a_r2_trap_privileged: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> next_pc_o[XLEN-1]);

  // R3: a trapping slot issues no memory access
  a_r3_trap_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !mem_en_o);

  // R4: link register write carries the old PC plus 4
  a_r4_trap_link: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (rf_we_o && rf_waddr_o == RAW'(LINK_IDX)
                && rf_wdata_o[XLEN-2:0] == $past(pc_i[XLEN-2:0]) + 31'd4));

  // R6: without a trap, user code stays in user mode
  a_r6_user_stays_user: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !trap_o && !$past(pc_i[XLEN-1])) |-> !next_pc_o[XLEN-1]);

  // R10: an empty slot leaves nothing behind
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_q |-> (!trap_o && !rf_we_o && !mem_en_o && $stable(next_pc_o)));
endmodule

// File: tb/test_illop_trap_unit.sv
`timescale 1ns/1ps
module test_illop_trap_unit;
  localparam logic [63:0] MASK = 64'hF0FF_FFFF_0000_FFF9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, stall_i = 1'b0, irq_i = 1'b0, br_take_i = 1'b0;
  logic        dp_we_i = 1'b0, dp_mem_i = 1'b0;
  logic [31:0] pc_i = '0, instr_i = '0, br_target_i = '0, dp_wdata_i = '0;
  logic [31:0] next_pc_o, rf_wdata_o;
  logic        trap_o, rf_we_o, mem_en_o;
  logic [4:0]  rf_waddr_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model_pc;

  always #5 clk = ~clk;

  illop_trap_unit i_illop_trap_unit (
    .clk, .rst_n, .valid_i, .stall_i, .pc_i, .instr_i, .irq_i, .br_take_i,
    .br_target_i, .dp_we_i, .dp_wdata_i, .dp_mem_i, .next_pc_o, .trap_o,
    .rf_we_o, .rf_waddr_o, .rf_wdata_o, .mem_en_o
  );

  function automatic logic [31:0] plus4(input logic [31:0] pc);
    logic [31:0] s;
    s = pc + 32'd4;
    return {pc[31], s[30:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Apply one slot on the falling edge, compare one falling edge later.
  task automatic slot(input logic v, input logic st, input logic [31:0] pc,
                      input logic [31:0] ins, input logic irq, input logic br,
                      input logic [31:0] tgt, input logic we, input logic [31:0] wd,
                      input logic mem);
    logic acc, ill, irqt, trap, e_we, e_mem;
    logic [31:0] e_pc, e_wd;
    logic [4:0]  e_wa;
    string tag;
    valid_i = v; stall_i = st; pc_i = pc; instr_i = ins; irq_i = irq;
    br_take_i = br; br_target_i = tgt; dp_we_i = we; dp_wdata_i = wd; dp_mem_i = mem;
    acc  = v && !st;
    ill  = !MASK[ins[31:26]];
    irqt = irq && !pc[31] && !ill;
    trap = acc && (ill || irqt);
    e_wa = ins[25:21]; e_wd = wd; e_we = acc && we; e_mem = acc && mem;
    if (!acc) begin
      tag = "R10"; e_pc = model_pc;
    end else if (ill) begin
      tag = irq ? "R9" : (pc[31] ? "R5" : "R2/R1");
      e_pc = 32'h8000_0004;
    end else if (irqt) begin
      tag = "R8"; e_pc = 32'h8000_0008;
    end else if (br) begin
      tag = "R7"; e_pc = {pc[31] & tgt[31], tgt[30:0]};
    end else begin
      tag = (irq && pc[31]) ? "R8" : "R6"; e_pc = plus4(pc);
    end
    if (trap) begin
      e_we = 1'b1; e_wa = 5'd30; e_wd = plus4(pc); e_mem = 1'b0;
    end
    model_pc = e_pc;
    @(negedge clk);
    chk({tag, " next_pc"}, next_pc_o, e_pc);
    chk({tag, " trap"}, {31'd0, trap_o}, {31'd0, trap});
    chk(trap ? "R3 mem" : {tag, " R12 mem"}, {31'd0, mem_en_o}, {31'd0, e_mem});
    chk(trap ? "R4 we" : {tag, " R12 we"}, {31'd0, rf_we_o}, {31'd0, e_we});
    if (e_we) begin
      chk(trap ? "R4 waddr" : "R12 waddr", {27'd0, rf_waddr_o}, {27'd0, e_wa});
      chk(trap ? "R4 wdata" : "R12 wdata", rf_wdata_o, e_wd);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rc);
    return {op, rc, 21'h0ABCD};
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_pc = 32'h8000_0000;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 next_pc", next_pc_o, 32'h8000_0000);
    chk("R11 flags", {29'd0, trap_o, rf_we_o, mem_en_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after release", next_pc_o, 32'h8000_0000);

    // Directed corners
    slot(1,0,32'h0000_0100, mk(6'd1,5'd3), 0,0,0, 1,32'h1111,1);   // R1 op 1
    slot(1,0,32'h0000_0200, mk(6'd2,5'd4), 0,0,0, 1,32'h2222,1);   // R1 op 2
    slot(1,0,32'h0000_0300, mk(6'd20,5'd5), 0,0,0, 1,32'h3,1);     // R1 op 20
    slot(1,0,32'h0000_0304, mk(6'd0,5'd6), 0,0,0, 1,32'h4,1);      // R12 legal op 0
    slot(1,0,32'hFFFF_FFFC, mk(6'd2,5'd7), 0,0,0, 1,32'h5,0);      // R5, R4 wrap
    slot(1,0,32'h7FFF_FFFC, mk(6'd3,5'd8), 0,0,0, 0,32'h6,0);      // R6 wrap
    slot(1,0,32'hFFFF_FFFC, mk(6'd63,5'd9), 0,0,0, 1,32'h7,1);     // R6 super wrap
    slot(1,0,32'h0000_1000, mk(6'd4,5'd1), 0,1,32'h8000_2000, 0,0,0); // R7 no raise
    slot(1,0,32'h8000_1000, mk(6'd4,5'd1), 0,1,32'h8000_2000, 0,0,0); // R7 keep
    slot(1,0,32'h0000_4000, mk(6'd5,5'd2), 1,0,0, 1,32'h9,1);      // R8 irq
    slot(1,0,32'h8000_4000, mk(6'd5,5'd2), 1,0,0, 1,32'hA,1);      // R8 ignored
    slot(1,0,32'h0000_5000, mk(6'd1,5'd2), 1,0,0, 1,32'hB,1);      // R9 priority
    slot(0,0,32'h0000_6000, mk(6'd1,5'd2), 1,0,0, 1,32'hC,1);      // R10 invalid
    slot(1,1,32'h0000_6000, mk(6'd2,5'd2), 0,0,0, 1,32'hD,1);      // R10 stall

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      op = ($urandom % 4 == 0) ? 6'($urandom % 3) : 6'($urandom);
      slot(($urandom % 8) != 0, ($urandom % 6) == 0,
           {$urandom} & 32'hFFFF_FFFC, {op, 26'($urandom)},
           ($urandom % 5) == 0, ($urandom % 3) == 0, $urandom,
           1'($urandom), $urandom, 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule